// File: doc/BRIEF.md
# Slave Serial Configuration Master

This block loads a configuration bitstream into an FPGA that listens on a slave-serial link. A start pulse arms it with a 32-bit byte count. It then pulls the active-low program line low for a fixed time, which resets the target, and checks that the target answers by holding its init line low. After release it waits for init to return high. Once init is high it takes bytes from an upstream valid/ready stream and shifts each one out most-significant bit first on a data line, against a configuration clock that idles high.

After the last data bit it supplies a set number of further clock cycles so that the target can finish its startup. It then reads the done line and reports one of four result codes together with a one-cycle completion pulse. Init and done are open-drain lines. They arrive through two-flop synchronisers.

The block also aborts a load early in two cases: when init falls while data is being clocked, and when the upstream stream stops supplying data while bytes are still owed. All delays are parameters counted in system clock cycles. The clock divider is derived from the system and target clock frequencies.

Top module: `sscfg_master`

## Requirements
- R1: Out of reset and whenever idle, `prog_n_o` is 1, `cclk_o` is 1, `busy_o` is 0, `s_ready_o` is 0 and `done_o` is 0.
- R2: A start drives `prog_n_o` low for exactly `PROG_LOW_CYC` system cycles. Elaboration rejects a value shorter than `MIN_PROG_NS`.
- R3: If the synchronised init reads high at the end of the program pulse, the attempt ends with result 1 (no reset acknowledge). No byte is accepted and no configuration clock is produced.
- R4: After release, if init stays low for `INIT_WAIT_CYC` cycles, the attempt ends with result 2 (init fault) and no clock is produced.
- R5: Each byte goes out most-significant bit first. `dout_o` changes only when `cclk_o` falls, and it is held steady across each rising edge, where the target captures it.
- R6: Each low phase of `cclk_o` lasts `ceil(CLK_HZ / (2*CCLK_HZ))` system cycles. Elaboration rejects a setting above 33 MHz.
- R7: If init falls while data or startup clocks are being sent, the attempt ends with result 2, clocking stops, and `cclk_o` returns high.
- R8: After the last data bit, exactly `EXTRA_CLKS` further rising edges of `cclk_o` are sent with `dout_o` at 1.
- R9: After the startup clocks and `SETTLE_CYC` cycles, a high done gives result 0 (ok) and a low done gives result 3 (not done). The result holds while the block is idle.
- R10: If `s_ready_o` stays high without `s_valid_i` for `STARVE_CYC` cycles while bytes are still owed, the attempt ends with result 3.
- R11: `busy_o` is high from start until completion. `done_o` is a single-cycle pulse per attempt, and a start while busy is ignored.
- R12: A length of zero accepts no bytes and sends only the `EXTRA_CLKS` startup clocks before checking done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, ignored while busy |
| len_i | input | LEN_W | Number of bitstream bytes, sampled at start |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | BYTE_W | Upstream byte |
| s_ready_o | output | 1 | Byte accepted when high together with valid |
| prog_n_o | output | 1 | Active-low program line to the target |
| cclk_o | output | 1 | Configuration clock, idles high |
| dout_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Target init line (asynchronous) |
| done_i | input | 1 | Target done line (asynchronous) |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 2 | 0 ok, 1 no reset acknowledge, 2 init fault, 3 not done |

## Verification
The hardest case to reach from the ports is init falling in the middle of a byte. Once that happens, clocking must stop and the clock must be driven back high, even though a half-sent byte is still held in the shifter. The bench models the target's init line in a process that counts the captured configuration clock edges. It pulls init low once a chosen bit count has been reached, so the drop lands mid-byte. The bench then checks that far fewer edges arrive than a full load would produce, and that the clock rests high. The starvation timeout is reached in a similar way: the stream supplies fewer bytes than the programmed length.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

   typedef enum logic [1:0] {
      RES_OK         = 2'd0,
      RES_NO_ACK     = 2'd1,
      RES_INIT_FAULT = 2'd2,
      RES_NOT_DONE   = 2'd3
   } sscfg_res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_WAIT,
      ST_LOAD,
      ST_START,
      ST_CHECK,
      ST_FIN
   } sscfg_st_e;

   function automatic int sscfg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sscfg_sync needs at least two stages");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= '0;
               else        stg[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= '0;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sscfg_tick.sv
module sscfg_tick #(
   parameter int HALF = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!en_i) cnt <= '0;
      else if (wrap)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign tick_o = en_i && wrap;
endmodule

// File: rtl/sscfg_serial.sv
module sscfg_serial #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         load_i,
   input  logic [W-1:0] byte_i,
   input  logic         pad_i,
   input  logic         flush_i,
   output logic         cclk_o,
   output logic         dout_o,
   output logic         full_o,
   output logic         idle_o,
   output logic         rise_o
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          full;
   logic          cclk;
   logic          dout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         full <= 1'b0;
         cclk <= 1'b1;
         dout <= 1'b1;
      end else if (flush_i) begin
         full <= 1'b0;
         cnt  <= '0;
         cclk <= 1'b1;
      end else if (load_i && !full) begin
         sh   <= byte_i;
         full <= 1'b1;
         cnt  <= '0;
      end else if (tick_i) begin
         if (cclk) begin
            if (full || pad_i) begin
               cclk <= 1'b0;
               dout <= full ? sh[W-1] : 1'b1;
            end
         end else begin
            cclk <= 1'b1;
            if (full) begin
               sh <= sh << 1;
               if (cnt == CW'(W - 1)) begin
                  full <= 1'b0;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   assign cclk_o = cclk;
   assign dout_o = dout;
   assign full_o = full;
   assign idle_o = !full && cclk;
   assign rise_o = tick_i && !cclk && !flush_i;
endmodule

// File: rtl/sscfg_master.sv
module sscfg_master
   import sscfg_pkg::*;
#(
   parameter int CLK_HZ        = 50_000_000,
   parameter int CCLK_HZ       = 25_000_000,
   parameter int MAX_CCLK_HZ   = 33_000_000,
   parameter int MIN_PROG_NS   = 500,
   parameter int LEN_W         = 32,
   parameter int BYTE_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int PROG_LOW_CYC  = 25,
   parameter int INIT_WAIT_CYC = 1000,
   parameter int STARVE_CYC    = 100000,
   parameter int EXTRA_CLKS    = 64,
   parameter int SETTLE_CYC    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              s_valid_i,
   input  logic [BYTE_W-1:0] s_data_i,
   output logic              s_ready_o,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              dout_o,
   input  logic              init_i,
   input  logic              done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        result_o
);
   localparam int HALF    = (CLK_HZ + 2*CCLK_HZ - 1) / (2*CCLK_HZ);
   localparam int TMR_MAX = sscfg_max(sscfg_max(PROG_LOW_CYC, INIT_WAIT_CYC),
                                      sscfg_max(STARVE_CYC, SETTLE_CYC));
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int EXT_W   = $clog2(EXTRA_CLKS + 1);

   generate
      if (CLK_HZ / (2*HALF) > MAX_CCLK_HZ) begin : g_bad_rate
         $error("configuration clock above the allowed maximum");
      end
      if (longint'(PROG_LOW_CYC) * 64'd1_000_000_000 <
          longint'(MIN_PROG_NS) * longint'(CLK_HZ)) begin : g_bad_prog
         $error("program pulse shorter than the minimum low time");
      end
      if (PROG_LOW_CYC < SYNC_STAGES + 2) begin : g_short_prog
         $error("program pulse shorter than the synchroniser delay");
      end
      if (EXTRA_CLKS < 1 || SETTLE_CYC < 1 || INIT_WAIT_CYC < 1 || STARVE_CYC < 1) begin : g_bad_cnt
         $error("cycle counts must be at least one");
      end
   endgenerate

   sscfg_st_e          state;
   sscfg_res_e         result_q;
   logic [TMR_W-1:0]   tmr;
   logic [EXT_W-1:0]   ext;
   logic [LEN_W-1:0]   left;
   logic               init_s, done_s;
   logic               tick, ser_full, ser_idle, ser_rise, ser_flush;
   logic               ready, accept, active;

   sscfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({init_i, done_i}),
      .q_o   ({init_s, done_s})
   );

   assign active    = (state == ST_LOAD) || (state == ST_START);
   assign ser_flush = active && !init_s;
   assign ready     = (state == ST_LOAD) && !ser_full && (left != '0) && init_s;
   assign accept    = ready && s_valid_i;

   sscfg_tick #(.HALF(HALF)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (active),
      .tick_o (tick)
   );

   sscfg_serial #(.W(BYTE_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .load_i  (accept),
      .byte_i  (s_data_i),
      .pad_i   (state == ST_START),
      .flush_i (ser_flush),
      .cclk_o  (cclk_o),
      .dout_o  (dout_o),
      .full_o  (ser_full),
      .idle_o  (ser_idle),
      .rise_o  (ser_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         result_q <= RES_OK;
         tmr      <= '0;
         ext      <= '0;
         left     <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state <= ST_PROG;
                  tmr   <= '0;
                  left  <= len_i;
               end
            end
            ST_PROG: begin
               if (tmr == TMR_W'(PROG_LOW_CYC - 1)) begin
                  tmr <= '0;
                  if (init_s) begin
                     result_q <= RES_NO_ACK;
                     state    <= ST_FIN;
                  end else begin
                     state <= ST_WAIT;
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_WAIT: begin
               if (init_s) begin
                  tmr   <= '0;
                  ext   <= '0;
                  state <= (left == '0) ? ST_START : ST_LOAD;
               end else if (tmr == TMR_W'(INIT_WAIT_CYC - 1)) begin
                  result_q <= RES_INIT_FAULT;
                  state    <= ST_FIN;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_LOAD: begin
               if (!init_s) begin
                  result_q <= RES_INIT_FAULT;
                  state    <= ST_FIN;
               end else if (accept) begin
                  left <= left - 1'b1;
                  tmr  <= '0;
               end else if (left == '0 && ser_idle) begin
                  ext   <= '0;
                  state <= ST_START;
               end else if (ready) begin
                  if (tmr == TMR_W'(STARVE_CYC - 1)) begin
                     result_q <= RES_NOT_DONE;
                     state    <= ST_FIN;
                  end else begin
                     tmr <= tmr + 1'b1;
                  end
               end
            end
            ST_START: begin
               if (!init_s) begin
                  result_q <= RES_INIT_FAULT;
                  state    <= ST_FIN;
               end else if (ser_rise) begin
                  if (ext == EXT_W'(EXTRA_CLKS - 1)) begin
                     tmr   <= '0;
                     state <= ST_CHECK;
                  end else begin
                     ext <= ext + 1'b1;
                  end
               end
            end
            ST_CHECK: begin
               if (tmr == TMR_W'(SETTLE_CYC - 1)) begin
                  result_q <= done_s ? RES_OK : RES_NOT_DONE;
                  state    <= ST_FIN;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign s_ready_o = ready;
   assign prog_n_o  = (state != ST_PROG);
   assign busy_o    = (state != ST_IDLE);
   assign done_o    = (state == ST_FIN);
   assign result_o  = result_q;
endmodule

// File: rtl/sscfg_chk.sv
module sscfg_chk #(
   parameter int PROG_LOW_CYC = 25
) (
   input logic       clk,
   input logic       rst_n,
   input logic       prog_n,
   input logic       cclk,
   input logic       dout,
   input logic       busy,
   input logic       done,
   input logic       ready,
   input logic [1:0] result
);
   logic [31:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (prog_n)           low_cnt <= '0;
      else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
   end

   // R1: idle outputs rest at their quiet levels
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cclk && prog_n && !ready && !done));

   // R2: program line released only after the full low time
   p_prog_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_n) |-> (low_cnt >= PROG_LOW_CYC));

   // R3: no clock and no byte intake while program is low
   p_no_clk_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> (cclk && !ready));

   // R5: data held across the capturing edge
   p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $stable(dout));

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: result held while idle
   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(result));
endmodule

bind sscfg_master sscfg_chk #(.PROG_LOW_CYC(PROG_LOW_CYC)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .prog_n (prog_n_o),
   .cclk   (cclk_o),
   .dout   (dout_o),
   .busy   (busy_o),
   .done   (done_o),
   .ready  (s_ready_o),
   .result (result_o)
);

// File: tb/sscfg_master_tb.sv
module sscfg_master_tb;
   localparam int PL   = 25;
   localparam int IW   = 40;
   localparam int SV   = 30;
   localparam int EX   = 16;
   localparam int SC   = 4;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] len_i = '0;
   logic        s_valid_i = 1'b0;
   logic [7:0]  s_data_i = '0;
   logic        s_ready_o, prog_n_o, cclk_o, dout_o, busy_o, done_o;
   logic        init_i, done_i = 1'b1;
   logic [1:0]  result_o;

   sscfg_master #(
      .CLK_HZ(50_000_000), .CCLK_HZ(12_500_000), .PROG_LOW_CYC(PL),
      .INIT_WAIT_CYC(IW), .STARVE_CYC(SV), .EXTRA_CLKS(EX), .SETTLE_CYC(SC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
      .prog_n_o(prog_n_o), .cclk_o(cclk_o), .dout_o(dout_o),
      .init_i(init_i), .done_i(done_i), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o)
   );

   always #10 clk = ~clk;

   int vectors = 0;
   int errors  = 0;
   int nbits   = 0;
   logic bits [0:511];
   int prog_low = 0, lowrun = 0, bad_low = 0, ndone = 0;
   bit ack_en = 1, rel_en = 1, dropped = 0;
   int drop_at = -1, relcnt = 0;

   function automatic logic [7:0] pat(input int i);
      return 8'hA5 ^ 8'(i * 37);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // captured configuration bits at each rising edge
   always @(posedge cclk_o) begin
      if (busy_o) begin
         if (nbits < 512) bits[nbits] = dout_o;
         nbits++;
      end
   end

   // target model for init and edge/pulse measurement
   initial begin
      init_i = 1'b1;
      forever begin
         @(negedge clk);
         if (!prog_n_o) begin
            init_i = ack_en ? 1'b0 : 1'b1;
            relcnt = 0; dropped = 0; prog_low++;
         end else if (drop_at >= 0 && nbits >= drop_at && busy_o) begin
            init_i = 1'b0; dropped = 1;
         end else if (!init_i && !dropped && rel_en) begin
            relcnt++;
            if (relcnt >= 5) init_i = 1'b1;
         end
         if (!cclk_o) lowrun++;
         else if (lowrun != 0) begin
            if (lowrun != HALF) bad_low++;
            lowrun = 0;
         end
         if (done_o) ndone++;
      end
   end

   task automatic feed(input int n, output int acc);
      acc = 0;
      for (int i = 0; i < n; i++) begin
         int guard = 0;
         s_data_i  = pat(i);
         s_valid_i = 1'b1;
         while (!s_ready_o && busy_o && guard < 5000) begin
            @(negedge clk); guard++;
         end
         if (!s_ready_o) break;
         @(negedge clk);
         acc++;
      end
      s_valid_i = 1'b0;
   endtask

   task automatic wait_done(output logic [1:0] res);
      int guard = 0;
      res = 2'bxx;
      while (!done_o && guard < 20000) begin
         @(negedge clk); guard++;
      end
      res = result_o;
      @(negedge clk);
   endtask

   task automatic begin_run(input int len);
      nbits = 0; prog_low = 0; bad_low = 0; lowrun = 0; ndone = 0;
      @(negedge clk);
      len_i = 32'(len); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_cfg(input int len, input int supply, output logic [1:0] res,
                          output int acc);
      begin_run(len);
      fork
         feed(supply, acc);
         wait_done(res);
      join
   endtask

   task automatic t_reset();
      chk(prog_n_o === 1'b1 && cclk_o === 1'b1, "R1 idle lines", int'(prog_n_o), 1);
      chk(busy_o === 1'b0 && s_ready_o === 1'b0 && done_o === 1'b0, "R1 idle flags",
          int'(busy_o), 0);
   endtask

   task automatic t_normal();
      logic [1:0] res; int acc; bit ok_bytes = 1; bit ok_pad = 1;
      ack_en = 1; rel_en = 1; drop_at = -1; done_i = 1'b1;
      run_cfg(4, 4, res, acc);
      chk(res == 2'd0, "R9 ok result", res, 0);
      chk(prog_low == PL, "R2 program low width", prog_low, PL);
      chk(acc == 4, "R5 bytes accepted", acc, 4);
      chk(nbits == 32 + EX, "R8 rising edge total", nbits, 32 + EX);
      for (int b = 0; b < 4; b++) begin
         logic [7:0] got;
         for (int k = 0; k < 8; k++) got[7-k] = bits[8*b+k];
         if (got != pat(b)) ok_bytes = 0;
      end
      chk(ok_bytes, "R5 msb-first bytes", int'(ok_bytes), 1);
      for (int k = 32; k < 32 + EX; k++) if (bits[k] !== 1'b1) ok_pad = 0;
      chk(ok_pad, "R8 startup bits high", int'(ok_pad), 1);
      chk(bad_low == 0, "R6 low phase length", bad_low, 0);
      chk(ndone == 1, "R11 single done pulse", ndone, 1);
      repeat (5) @(negedge clk);
      chk(result_o == 2'd0 && !busy_o, "R9 result held idle", result_o, 0);
   endtask

   task automatic t_done_low();
      logic [1:0] res; int acc;
      done_i = 1'b0;
      run_cfg(2, 2, res, acc);
      chk(res == 2'd3, "R9 done low result", res, 3);
      done_i = 1'b1;
   endtask

   task automatic t_no_ack();
      logic [1:0] res; int acc;
      ack_en = 0;
      run_cfg(3, 3, res, acc);
      chk(res == 2'd1, "R3 no-ack result", res, 1);
      chk(nbits == 0 && acc == 0, "R3 no clocks or bytes", nbits, 0);
      ack_en = 1;
   endtask

   task automatic t_init_stuck();
      logic [1:0] res; int acc;
      rel_en = 0;
      run_cfg(3, 3, res, acc);
      chk(res == 2'd2, "R4 init stuck result", res, 2);
      chk(nbits == 0, "R4 no clocks", nbits, 0);
      rel_en = 1;
   endtask

   task automatic t_drop();
      logic [1:0] res; int acc;
      drop_at = 12;
      run_cfg(4, 4, res, acc);
      chk(res == 2'd2, "R7 init drop result", res, 2);
      chk(nbits < 20, "R7 clocking stopped", nbits, 12);
      chk(cclk_o === 1'b1, "R7 clock rests high", int'(cclk_o), 1);
      drop_at = -1;
   endtask

   task automatic t_starve();
      logic [1:0] res; int acc;
      run_cfg(4, 2, res, acc);
      chk(res == 2'd3, "R10 starvation result", res, 3);
      chk(nbits == 16, "R10 only supplied bits", nbits, 16);
   endtask

   task automatic t_zero();
      logic [1:0] res; int acc;
      s_valid_i = 1'b0;
      run_cfg(0, 0, res, acc);
      chk(res == 2'd0, "R12 zero-length result", res, 0);
      chk(nbits == EX, "R12 startup clocks only", nbits, EX);
   endtask

   task automatic t_restart_busy();
      logic [1:0] res; int acc;
      begin_run(2);
      fork
         feed(2, acc);
         wait_done(res);
         begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
         end
      join
      repeat (60) @(negedge clk);
      chk(res == 2'd0, "R11 run unaffected", res, 0);
      chk(ndone == 1 && !busy_o, "R11 start while busy ignored", ndone, 1);
      chk(nbits == 16 + EX, "R11 edge total unchanged", nbits, 16 + EX);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_normal();
      t_done_low();
      t_no_ack();
      t_init_stuck();
      t_drop();
      t_starve();
      t_zero();
      t_restart_busy();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vectors++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule